// File: doc/BRIEF.md
# Configuration Space with Base Address Decode

This block holds the 256-byte configuration space of a single PCI function. A host-side access port addresses it by byte offset, with a transfer length of one, two or four bytes. Bytes are packed little-endian: the byte at the lowest offset travels on data bits 7:0. The identity bytes, header type and interrupt pin come from parameters and cannot be changed by writes. All other bytes act as plain storage.

Up to six base address registers are described by parameters. Each one has a fixed power-of-two size and a type, either I/O or memory. A size of zero marks a register as unused. A dword write to an implemented base register is aligned to the region size and tagged with the type bit. A change to a base register, or to the command word, triggers a re-evaluation of every region. That evaluation produces a registered mapped flag and base address for each region, for use by an address decoder. It also produces a one-cycle change strobe for each region whose mapping moved.

Top module: `cfg_bar_space`

## Requirements
- R1: After reset the identity bytes hold their parameter values: vendor word at 0x00, device word at 0x02, revision at 0x08, class at 0x09-0x0B, header type at 0x0E and interrupt pin at 0x3D. Each implemented base register reads as its type bit: 1 for I/O, 0 for memory. Every other byte reads zero, and no region is mapped.
- R2: `accLen` selects the length: 0 means one byte, 1 means two bytes, and 2 or 3 means four bytes. Reads are little-endian. On reads shorter than four bytes, the unused upper bytes of `rdData` are zero.
- R3: Writes to the bytes at 0x00-0x03, 0x08-0x0B, 0x0E and 0x3D are ignored. A multi-byte write is applied byte by byte at consecutive offsets. The bytes of such a write that are not protected are still stored.
- R4: A four-byte write at offset o, with 0x10 <= o < 0x10+4*NUM_BARS, targets base register (o-0x10)/4. If that region's size is nonzero, the stored dword is the data with its low log2(size) bits cleared, ORed with the type bit in bit 0.
- R5: A base register write to a zero-size region is stored as ordinary bytes. So is a one- or two-byte write into a base register. Neither write re-evaluates the mappings.
- R6: An I/O region can be mapped only while command bit 0 (offset 0x04) is set. A memory region can be mapped only while command bit 1 is set.
- R7: An I/O region is unmapped if its aligned base is zero, if base+size-1 does not exceed the base, or if base+size-1 is at least 0x10000.
- R8: A memory region is unmapped if its aligned base is zero, if base+size-1 does not exceed the base, or if base+size-1 equals 0xFFFFFFFF.
- R9: Region outputs change only on re-evaluation. Re-evaluation is triggered by a base register write to a sized region, or by any write whose bytes overlap offsets 0x04-0x05. The new outputs appear at the second rising edge after the write edge.
- R10: On re-evaluation, `regionChange` pulses for one cycle for each region whose mapped flag or base changed.
- R11: An unmapped region drives a base of zero. `regionSize` always shows the parameter sizes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Write strobe, one access per cycle |
| accAddr | input | 8 | Byte offset of the access |
| accLen | input | 2 | Length code (0: byte, 1: word, 2/3: dword) |
| wrData | input | 32 | Write data, little-endian lanes |
| rdData | output | 32 | Combinational read data for accAddr/accLen |
| regionValid | output | NUM_BARS | Region currently mapped |
| regionBase | output | 32*NUM_BARS | Decoded base per region, zero when unmapped |
| regionSize | output | 32*NUM_BARS | Configured size per region |
| regionChange | output | NUM_BARS | One-cycle strobe on a mapping change |

## Verification
The assertions assume that writes come only as single-cycle `wrEn` pulses and that `wrEn` stays low during reset. The re-evaluation window is counted from the write edge, and that count relies on both conditions. They also assume that the size parameters are powers of two, at least four for I/O regions, so that the type bit never overlaps the base field. The directed tests leave at least one idle cycle after every write before they sample a region output. They use only the default parameters, which meet these conditions.

// File: rtl/cfg_bar_pkg.sv
package cfg_bar_pkg;

  localparam logic [1:0] LEN_BYTE = 2'd0;
  localparam logic [1:0] LEN_WORD = 2'd1;

  typedef struct packed {
    logic [3:0] laneWe;   // per-lane plain byte store
    logic       barWr;    // masked base register store
    logic [2:0] barIdx;   // targeted base register
    logic       remap;    // re-evaluate all mappings this cycle
  } cfg_strobe_t;

  function automatic logic isLocked(input logic [7:0] off);
    case (off)
      8'h00, 8'h01, 8'h02, 8'h03,
      8'h08, 8'h09, 8'h0A, 8'h0B,
      8'h0E, 8'h3D: isLocked = 1'b1;
      default:      isLocked = 1'b0;
    endcase
  endfunction

  function automatic logic [2:0] lenBytes(input logic [1:0] code);
    case (code)
      LEN_BYTE: lenBytes = 3'd1;
      LEN_WORD: lenBytes = 3'd2;
      default:  lenBytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/cfg_bar_ctrl.sv
module cfg_bar_ctrl
  import cfg_bar_pkg::*;
#(
  parameter int NUM_BARS = 6,
  parameter logic [NUM_BARS*32-1:0] BAR_SIZE = '0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wrEn,
  input  logic [7:0]  accAddr,
  input  logic [1:0]  accLen,
  output cfg_strobe_t strb
);

  localparam logic [7:0] BAR_FIRST = 8'h10;
  localparam int         BAR_LIMIT = 16 + 4 * NUM_BARS;

  logic [2:0] nBytes;
  logic       inBarWin;
  logic [7:0] barOff;
  logic [2:0] barIdx;
  logic       barSized;
  logic       barPath;
  logic [8:0] accEnd;
  logic       cmdHit;
  logic       remapQ;
  logic [3:0] laneWe;

  assign nBytes   = lenBytes(accLen);
  assign inBarWin = (accAddr >= BAR_FIRST) && (int'(accAddr) < BAR_LIMIT);
  assign barOff   = accAddr - BAR_FIRST;
  assign barIdx   = barOff[4:2];

  always_comb begin
    barSized = 1'b0;
    for (int i = 0; i < NUM_BARS; i++) begin
      if (barIdx == 3'(i) && BAR_SIZE[i*32 +: 32] != 32'd0) barSized = 1'b1;
    end
  end

  assign barPath = wrEn && (nBytes == 3'd4) && inBarWin && barSized;
  assign accEnd  = {1'b0, accAddr} + {6'd0, nBytes};
  assign cmdHit  = wrEn && !barPath && (accEnd > 9'd4) && (accAddr < 8'd6);

  generate
    for (genvar k = 0; k < 4; k++) begin : g_lane
      assign laneWe[k] = wrEn && !barPath && (3'(k) < nBytes)
                         && !isLocked(accAddr + 8'(k));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) remapQ <= 1'b0;
    else     remapQ <= barPath || cmdHit;
  end

  always_comb begin
    strb.laneWe = laneWe;
    strb.barWr  = barPath;
    strb.barIdx = barIdx;
    strb.remap  = remapQ;
  end

endmodule

// File: rtl/cfg_bar_data.sv
module cfg_bar_data
  import cfg_bar_pkg::*;
#(
  parameter int NUM_BARS = 6,
  parameter logic [NUM_BARS*32-1:0] BAR_SIZE = '0,
  parameter logic [NUM_BARS-1:0]    BAR_IO   = '0,
  parameter logic [15:0] VENDOR_ID   = 16'h0,
  parameter logic [15:0] DEVICE_ID   = 16'h0,
  parameter logic [7:0]  REVISION    = 8'h0,
  parameter logic [23:0] CLASS_CODE  = 24'h0,
  parameter logic [7:0]  HEADER_TYPE = 8'h0,
  parameter logic [7:0]  INT_PIN     = 8'h0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [7:0]               accAddr,
  input  logic [1:0]               accLen,
  input  logic [31:0]              wrData,
  input  cfg_strobe_t              strb,
  output logic [31:0]              rdData,
  output logic [NUM_BARS-1:0]      regionValid,
  output logic [NUM_BARS*32-1:0]   regionBase,
  output logic [NUM_BARS-1:0]      regionChange
);

  localparam int         CFG_BYTES = 256;
  localparam logic [7:0] BAR_FIRST = 8'h10;
  localparam logic [31:0] IO_LIMIT = 32'h0001_0000;

  logic [7:0]  cfgMem [CFG_BYTES];
  logic [15:0] cmdWord;
  logic [2:0]  nBytes;
  logic [31:0] selSize;
  logic        selIo;
  logic [31:0] barStore;
  logic [7:0]  barAddr;

  logic [NUM_BARS-1:0]    candValid;
  logic [NUM_BARS*32-1:0] candBase;

  assign cmdWord = {cfgMem[5], cfgMem[4]};
  assign nBytes  = lenBytes(accLen);

  always_comb begin
    selSize = '0;
    selIo   = 1'b0;
    for (int i = 0; i < NUM_BARS; i++) begin
      if (strb.barIdx == 3'(i)) begin
        selSize = BAR_SIZE[i*32 +: 32];
        selIo   = BAR_IO[i];
      end
    end
  end

  assign barStore = (wrData & ~(selSize - 32'd1)) | {31'd0, selIo};
  assign barAddr  = BAR_FIRST + {3'd0, strb.barIdx, 2'b00};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < CFG_BYTES; j++) cfgMem[j] <= 8'h00;
      cfgMem[8'h00] <= VENDOR_ID[7:0];
      cfgMem[8'h01] <= VENDOR_ID[15:8];
      cfgMem[8'h02] <= DEVICE_ID[7:0];
      cfgMem[8'h03] <= DEVICE_ID[15:8];
      cfgMem[8'h08] <= REVISION;
      cfgMem[8'h09] <= CLASS_CODE[7:0];
      cfgMem[8'h0A] <= CLASS_CODE[15:8];
      cfgMem[8'h0B] <= CLASS_CODE[23:16];
      cfgMem[8'h0E] <= HEADER_TYPE;
      cfgMem[8'h3D] <= INT_PIN;
      for (int i = 0; i < NUM_BARS; i++) begin
        cfgMem[8'(16 + 4 * i)] <= {7'd0, BAR_IO[i] && (BAR_SIZE[i*32 +: 32] != 32'd0)};
      end
    end else if (strb.barWr) begin
      for (int k = 0; k < 4; k++) cfgMem[barAddr + 8'(k)] <= barStore[k*8 +: 8];
    end else begin
      for (int k = 0; k < 4; k++) begin
        if (strb.laneWe[k]) cfgMem[accAddr + 8'(k)] <= wrData[k*8 +: 8];
      end
    end
  end

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      rdData[k*8 +: 8] = (3'(k) < nBytes) ? cfgMem[accAddr + 8'(k)] : 8'h00;
    end
  end

  generate
    for (genvar i = 0; i < NUM_BARS; i++) begin : g_dec
      localparam logic [31:0] SZ = BAR_SIZE[i*32 +: 32];
      if (SZ == 32'd0) begin : g_none
        assign candValid[i]          = 1'b0;
        assign candBase[i*32 +: 32]  = 32'd0;
      end else begin : g_live
        localparam int OFF = 16 + 4 * i;
        logic [31:0] rawBar, alignBase, lastByte;
        logic        spaceOn, rangeOk;
        assign rawBar    = {cfgMem[OFF+3], cfgMem[OFF+2], cfgMem[OFF+1], cfgMem[OFF]};
        assign alignBase = rawBar & ~(SZ - 32'd1);
        assign lastByte  = alignBase + SZ - 32'd1;
        if (BAR_IO[i]) begin : g_io
          assign spaceOn = cmdWord[0];
          assign rangeOk = (alignBase != 32'd0) && (lastByte > alignBase)
                           && (lastByte < IO_LIMIT);
        end else begin : g_mem
          assign spaceOn = cmdWord[1];
          assign rangeOk = (alignBase != 32'd0) && (lastByte > alignBase)
                           && (lastByte != 32'hFFFF_FFFF);
        end
        assign candValid[i]         = spaceOn && rangeOk;
        assign candBase[i*32 +: 32] = (spaceOn && rangeOk) ? alignBase : 32'd0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      regionValid  <= '0;
      regionBase   <= '0;
      regionChange <= '0;
    end else if (strb.remap) begin
      regionValid <= candValid;
      regionBase  <= candBase;
      for (int i = 0; i < NUM_BARS; i++) begin
        regionChange[i] <= (candValid[i] != regionValid[i])
                           || (candBase[i*32 +: 32] != regionBase[i*32 +: 32]);
      end
    end else begin
      regionChange <= '0;
    end
  end

endmodule

// File: rtl/cfg_bar_space.sv
module cfg_bar_space
  import cfg_bar_pkg::*;
#(
  parameter int NUM_BARS = 6,
  parameter logic [NUM_BARS*32-1:0] BAR_SIZE =
    {32'h0, 32'h0010_0000, 32'h0, 32'h8, 32'h1000, 32'h20},
  parameter logic [NUM_BARS-1:0] BAR_IO = 6'b000101,
  parameter logic [15:0] VENDOR_ID   = 16'hABCD,
  parameter logic [15:0] DEVICE_ID   = 16'h1234,
  parameter logic [7:0]  REVISION    = 8'h05,
  parameter logic [23:0] CLASS_CODE  = 24'h112233,
  parameter logic [7:0]  HEADER_TYPE = 8'h00,
  parameter logic [7:0]  INT_PIN     = 8'h01
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wrEn,
  input  logic [7:0]             accAddr,
  input  logic [1:0]             accLen,
  input  logic [31:0]            wrData,
  output logic [31:0]            rdData,
  output logic [NUM_BARS-1:0]    regionValid,
  output logic [NUM_BARS*32-1:0] regionBase,
  output logic [NUM_BARS*32-1:0] regionSize,
  output logic [NUM_BARS-1:0]    regionChange
);

  cfg_strobe_t strb;

  assign regionSize = BAR_SIZE;

  cfg_bar_ctrl #(.NUM_BARS(NUM_BARS), .BAR_SIZE(BAR_SIZE)) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .accAddr(accAddr),
    .accLen(accLen), .strb(strb)
  );

  cfg_bar_data #(
    .NUM_BARS(NUM_BARS), .BAR_SIZE(BAR_SIZE), .BAR_IO(BAR_IO),
    .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .REVISION(REVISION),
    .CLASS_CODE(CLASS_CODE), .HEADER_TYPE(HEADER_TYPE), .INT_PIN(INT_PIN)
  ) u_data (
    .clk(clk), .rst(rst), .accAddr(accAddr), .accLen(accLen),
    .wrData(wrData), .strb(strb), .rdData(rdData),
    .regionValid(regionValid), .regionBase(regionBase),
    .regionChange(regionChange)
  );

endmodule

// File: rtl/cfg_bar_space_chk.sv
module cfg_bar_space_chk #(
  parameter int NUM_BARS = 6,
  parameter logic [NUM_BARS*32-1:0] BAR_SIZE = '0,
  parameter logic [NUM_BARS-1:0]    BAR_IO   = '0
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   wrEn,
  input logic [1:0]             accLen,
  input logic [31:0]            rdData,
  input logic [NUM_BARS-1:0]    regionValid,
  input logic [NUM_BARS*32-1:0] regionBase,
  input logic [NUM_BARS-1:0]    regionChange
);

  // R2
  short_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (accLen == 2'd0) |-> (rdData[31:8] == 24'd0));

  // R9
  map_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(wrEn, 2) |-> ($stable(regionValid) && $stable(regionBase)));

  // R10
  change_source_chk: assert property (@(posedge clk) disable iff (rst)
    (regionChange != '0) |-> $past(wrEn, 2));

  generate
    for (genvar i = 0; i < NUM_BARS; i++) begin : g_reg
      localparam logic [31:0] SZ = BAR_SIZE[i*32 +: 32];
      // R11
      idle_base_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !regionValid[i] |-> (regionBase[i*32 +: 32] == 32'd0));
      // R7
      live_base_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        regionValid[i] |-> ((regionBase[i*32 +: 32] != 32'd0)
                            && ((regionBase[i*32 +: 32] & (SZ - 32'd1)) == 32'd0)));
      if (BAR_IO[i]) begin : g_io
        // R7
        io_window_chk: assert property (@(posedge clk) disable iff (rst)
          regionValid[i] |-> ((regionBase[i*32 +: 32] + SZ - 32'd1) < 32'h0001_0000));
      end else begin : g_mem
        // R8
        mem_top_chk: assert property (@(posedge clk) disable iff (rst)
          regionValid[i] |-> ((regionBase[i*32 +: 32] + SZ - 32'd1) != 32'hFFFF_FFFF));
      end
    end
  endgenerate

endmodule

bind cfg_bar_space cfg_bar_space_chk #(
  .NUM_BARS(NUM_BARS), .BAR_SIZE(BAR_SIZE), .BAR_IO(BAR_IO)
) u_chk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .accLen(accLen), .rdData(rdData),
  .regionValid(regionValid), .regionBase(regionBase),
  .regionChange(regionChange)
);

// File: tb/cfg_bar_space_bench.sv
module cfg_bar_space_bench;

  localparam int NB = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wrEn = 1'b0;
  logic [7:0]    accAddr = 8'h00;
  logic [1:0]    accLen = 2'd2;
  logic [31:0]   wrData = 32'h0;
  logic [31:0]   rdData;
  logic [NB-1:0] regionValid;
  logic [NB*32-1:0] regionBase;
  logic [NB*32-1:0] regionSize;
  logic [NB-1:0] regionChange;

  int checkCount = 0;
  int failCount  = 0;
  bit benchDone  = 1'b0;

  always #10 clk = ~clk;

  cfg_bar_space u_cfg_bar_space (
    .clk(clk), .rst(rst), .wrEn(wrEn), .accAddr(accAddr), .accLen(accLen),
    .wrData(wrData), .rdData(rdData), .regionValid(regionValid),
    .regionBase(regionBase), .regionSize(regionSize),
    .regionChange(regionChange)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [1:0] l, input logic [31:0] d);
    @(negedge clk);
    accAddr = a; accLen = l; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [7:0] a, input logic [1:0] l, output logic [31:0] d);
    @(negedge clk);
    accAddr = a; accLen = l;
    #1 d = rdData;
  endtask

  // wait for the re-evaluation edge, sampled away from the edge
  task automatic settle();
    @(negedge clk);
  endtask

  function automatic logic [31:0] baseOf(input int i);
    return regionBase[i*32 +: 32];
  endfunction

  task automatic testReset();
    logic [31:0] v;
    doRead(8'h00, 2'd2, v); check("R1 id dword", v, 32'h1234ABCD);
    doRead(8'h08, 2'd2, v); check("R1 rev/class", v, 32'h11223305);
    doRead(8'h3C, 2'd2, v); check("R1 int pin", v, 32'h00000100);
    doRead(8'h10, 2'd2, v); check("R1 io bar type", v, 32'h00000001);
    doRead(8'h14, 2'd2, v); check("R1 mem bar type", v, 32'h00000000);
    doRead(8'h04, 2'd1, v); check("R1 command", v, 32'h0);
    check("R1 no region mapped", 32'(regionValid), 32'h0);
    check("R11 size0", regionSize[31:0], 32'h20);
    check("R11 size4", regionSize[4*32 +: 32], 32'h0010_0000);
    doRead(8'h01, 2'd0, v); check("R2 byte read", v, 32'h000000AB);
    doRead(8'h02, 2'd1, v); check("R2 word read", v, 32'h00001234);
  endtask

  task automatic testProtect();
    logic [31:0] v;
    doWrite(8'h00, 2'd2, 32'hFFFF_FFFF);
    doRead(8'h00, 2'd2, v); check("R3 id locked", v, 32'h1234ABCD);
    doWrite(8'h3C, 2'd1, 32'h0000_BEEF);
    doRead(8'h3C, 2'd1, v); check("R3 pin locked, line stored", v, 32'h000001EF);
    doWrite(8'h0C, 2'd2, 32'hAABB_CCDD);
    doRead(8'h0C, 2'd2, v); check("R3 header locked in dword", v, 32'hAA00CCDD);
    doWrite(8'h40, 2'd1, 32'h0000_5678);
    doRead(8'h41, 2'd0, v); check("R2 little-endian byte", v, 32'h00000056);
    doWrite(8'h08, 2'd3, 32'h0);
    doRead(8'h08, 2'd2, v); check("R3 class locked", v, 32'h11223305);
  endtask

  task automatic testBarStore();
    logic [31:0] v;
    doWrite(8'h10, 2'd2, 32'h0000_C0FF);
    doRead(8'h10, 2'd2, v); check("R4 io bar masked", v, 32'h0000_C0E1);
    doWrite(8'h14, 2'd2, 32'hFEDC_BFFF);
    doRead(8'h14, 2'd2, v); check("R4 mem bar masked", v, 32'hFEDC_B000);
    doWrite(8'h1C, 2'd2, 32'h1234_5678);
    doRead(8'h1C, 2'd2, v); check("R5 unsized bar plain", v, 32'h1234_5678);
    settle();
    check("R6 no enable no map", 32'(regionValid), 32'h0);
  endtask

  task automatic testEnable();
    logic [31:0] v;
    doWrite(8'h04, 2'd1, 32'h0000_0001);
    settle();
    check("R6 io enabled", 32'(regionValid), 32'h01);
    check("R6 io base", baseOf(0), 32'h0000_C0E0);
    check("R10 strobe io", 32'(regionChange), 32'h01);
    settle();
    check("R10 strobe one cycle", 32'(regionChange), 32'h00);
    doWrite(8'h04, 2'd1, 32'h0000_0003);
    settle();
    check("R6 mem enabled", 32'(regionValid), 32'h03);
    check("R6 mem base", baseOf(1), 32'hFEDC_B000);
    check("R10 strobe mem only", 32'(regionChange), 32'h02);
    doRead(8'h04, 2'd1, v); check("R2 command readback", v, 32'h0003);
  endtask

  task automatic testIoBounds();
    doWrite(8'h18, 2'd2, 32'h0000_FFF9);
    settle();
    check("R7 io top edge mapped", 32'(regionValid), 32'h07);
    check("R7 io top base", baseOf(2), 32'h0000_FFF8);
    doWrite(8'h18, 2'd2, 32'h0001_0000);
    settle();
    check("R7 io above 64K", 32'(regionValid), 32'h03);
    check("R11 dropped base zero", baseOf(2), 32'h0);
    check("R10 strobe on drop", 32'(regionChange), 32'h04);
    doWrite(8'h10, 2'd2, 32'h0);
    settle();
    check("R7 io base zero", 32'(regionValid), 32'h02);
  endtask

  task automatic testMemBounds();
    doWrite(8'h20, 2'd2, 32'hFFF0_0000);
    settle();
    check("R8 mem end all-ones", 32'(regionValid), 32'h02);
    check("R10 no strobe no change", 32'(regionChange), 32'h00);
    doWrite(8'h20, 2'd2, 32'hFFE0_0000);
    settle();
    check("R8 mem below top", 32'(regionValid), 32'h12);
    check("R8 mem base", baseOf(4), 32'hFFE0_0000);
  endtask

  task automatic testTrigger();
    logic [31:0] v;
    doWrite(8'h17, 2'd0, 32'h0000_0040);
    settle();
    doRead(8'h14, 2'd2, v); check("R5 byte into bar stored", v, 32'h40DC_B000);
    check("R9 no remap on byte bar write", baseOf(1), 32'hFEDC_B000);
    check("R9 no strobe", 32'(regionChange), 32'h00);
    doWrite(8'h05, 2'd0, 32'h0000_0000);
    settle();
    check("R9 command byte remaps", baseOf(1), 32'h40DC_B000);
    check("R10 strobe after remap", 32'(regionChange), 32'h02);
    doWrite(8'h04, 2'd1, 32'h0000_0000);
    settle();
    check("R6 all disabled", 32'(regionValid), 32'h00);
    check("R10 strobes on disable", 32'(regionChange), 32'h12);
    check("R11 base cleared", baseOf(4), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testReset();
    testProtect();
    testBarStore();
    testEnable();
    testIoBounds();
    testMemBounds();
    testTrigger();
    repeat (2) @(negedge clk);
    benchDone = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!benchDone) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

endmodule